// File: doc/BRIEF.md
# Host Mailbox Port

This block sits between an external host and a processor core and acts as a small dual-ported mailbox. It holds six 16-bit message registers and two status words. The host reaches them through a 3-bit address, a select, separate read and write strobes, and a width pin that narrows the port to 8 bits. The core reaches them through a plain synchronous register port that also exposes an interrupt mask.

The host side runs with no relation to the core clock. Both strobes pass through a synchronizer, and only the rising edge of a synchronized strobe counts as an access. For every message register the block keeps two flags. One records that the host wrote it last and is cleared when the core reads it. The other records that the core wrote it last and is cleared when the host reads it. A host write or a host read of a message register can raise a one-cycle interrupt toward the core, gated per register by the mask.

The host can also request a core reset. The block then drives a reset pulse of a fixed number of core cycles.

Top module: `hostmbox_top`

## Requirements
- R1: After reset the mask (core address 8) reads 0x0000, status word 6 reads 0x0000, status word 7 reads 0x0001, both interrupts, the reset pulse and host_ack are low, and host_oe is 2'b00.
- R2: A host write to address n (0..5) in 16-bit mode stores the full word, which the core then reads at core address n and the host at host address n. It also sets bit n of status word 6 (the host-wrote flag).
- R3: A core read of core address n (0..5) clears bit n of status word 6.
- R4: A core write to core address n (0..5) stores the word and sets bit 8+n of status word 6 (the core-wrote flag). A host read of host address n clears that bit.
- R5: With host_byte_mode=1, a host write stores zeros in bits 15:8. A host read drives host_oe=2'b01 and leaves host_rdata[15:8] at zero. With host_byte_mode=0, a host read drives host_oe=2'b11.
- R6: A host write to message register n gives exactly one cycle of irq_host_wr when mask bit n is 1, and none when it is 0.
- R7: A host read of message register n gives exactly one cycle of irq_host_rd when mask bit 8+n is 1, and none when it is 0.
- R8: A host write to address 7 with bit 7 set drives sw_rst_pulse high for exactly SRST_CYCLES (5) core cycles. Bit 0 of status word 7 reads 0 during the pulse and 1 otherwise. A host write to address 7 with bit 7 clear, or any host write to address 6, changes no state.
- R9: host_ack rises once a host access has been taken and falls after the strobe is released. host_oe is 2'b00 whenever no host read is under way.
- R10: When a flag is set and cleared in the same core cycle, the set wins. This covers a host write coinciding with a core read of the same register, and a core write coinciding with a host read of the same register.
- R11: A strobe held high counts as one access only. A host-wrote flag cleared by the core while the host still holds its write strobe stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs | input | 1 | Host select, active high |
| host_rd | input | 1 | Host read strobe, active high, asynchronous |
| host_wr | input | 1 | Host write strobe, active high, asynchronous |
| host_addr | input | 3 | Host register address: 0..5 message, 6..7 status |
| host_byte_mode | input | 1 | 1 = 8-bit host port, 0 = 16-bit |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_oe | output | 2 | Byte output enables {upper, lower} |
| host_ack | output | 1 | Host access taken |
| core_addr | input | 4 | Core address: 0..5 message, 6..7 status, 8 mask |
| core_we | input | 1 | Core write enable |
| core_re | input | 1 | Core read enable (side effects only) |
| core_wdata | input | 16 | Core write data |
| core_rdata | output | 16 | Core read data for core_addr |
| irq_host_wr | output | 1 | Host-write interrupt pulse |
| irq_host_rd | output | 1 | Host-read interrupt pulse |
| sw_rst_pulse | output | 1 | Reset pulse requested by the host |

## Verification
A long run of random host and core accesses covers random registers, random data, random width modes and a random mask. This separates correct flag set and clear from crossed flag indices, and separates correct mask gating from gating by the wrong mask half. Directed cases align a host commit with an opposing core access in the same cycle to tell set-priority from clear-priority. A held write strobe tells edge detection from level detection. Soft-reset requests with and without the trigger bit measure the pulse length, which exposes off-by-one counters.

// File: rtl/hostmbox_pkg.sv
package hostmbox_pkg;
    localparam int MBX_DW   = 16;
    localparam int MBX_NUM  = 6;
    localparam int HADDR_W  = 3;
    localparam int CADDR_W  = 4;
    localparam int CW_OFS   = 8;   // core-wrote flags and read-irq mask bits start here
    localparam int SRST_BIT = 7;   // trigger bit in a host write to status word 7

    localparam logic [HADDR_W-1:0] HA_STAT_LO = 3'd6;
    localparam logic [HADDR_W-1:0] HA_STAT_HI = 3'd7;
    localparam logic [CADDR_W-1:0] CA_STAT_LO = 4'd6;
    localparam logic [CADDR_W-1:0] CA_STAT_HI = 4'd7;
    localparam logic [CADDR_W-1:0] CA_MASK    = 4'd8;

    typedef logic [MBX_DW-1:0]  word_t;
    typedef logic [MBX_NUM-1:0] flags_t;

    // Zero the upper byte when the host port runs 8 bits wide.
    function automatic word_t fold_width(word_t d, logic byte_mode);
        return byte_mode ? {8'h00, d[7:0]} : d;
    endfunction

    function automatic word_t pack_flags(flags_t hw, flags_t cw);
        word_t r = '0;
        r[MBX_NUM-1:0]             = hw;
        r[CW_OFS +: MBX_NUM]       = cw;
        return r;
    endfunction
endpackage

// File: rtl/hostmbox_sync.sv
module hostmbox_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [STAGES-1:0][W-1:0] chain;
    logic [W-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= '0;
        end else begin
            chain[0] <= async_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
            prev <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/hostmbox_srst.sv
module hostmbox_srst #(
    parameter int CYCLES = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                remain <= '0;
        else if (start)         remain <= CNT_W'(CYCLES);
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/hostmbox_regs.sv
module hostmbox_regs
    import hostmbox_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               h_we,
    input  logic               h_re,
    input  logic [HADDR_W-1:0] h_addr,
    input  word_t              h_wdata,
    input  logic               c_we,
    input  logic               c_re,
    input  logic [CADDR_W-1:0] c_addr,
    input  word_t              c_wdata,
    input  logic               srst_busy,
    output word_t              h_view,
    output word_t              c_rdata,
    output logic               irq_hwr,
    output logic               irq_hrd,
    output logic               srst_start,
    output word_t              mask_q
);
    word_t  mbx [MBX_NUM];
    flags_t hw_q, cw_q;
    flags_t h_wr_hit, h_rd_hit, c_wr_hit, c_rd_hit;
    word_t  stat_lo, stat_hi;

    genvar g;
    generate
        for (g = 0; g < MBX_NUM; g++) begin : g_hit
            assign h_wr_hit[g] = h_we && (h_addr == HADDR_W'(g));
            assign h_rd_hit[g] = h_re && (h_addr == HADDR_W'(g));
            assign c_wr_hit[g] = c_we && (c_addr == CADDR_W'(g));
            assign c_rd_hit[g] = c_re && (c_addr == CADDR_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MBX_NUM; i++) mbx[i] <= '0;
            hw_q    <= '0;
            cw_q    <= '0;
            mask_q  <= '0;
            irq_hwr <= 1'b0;
            irq_hrd <= 1'b0;
        end else begin
            for (int i = 0; i < MBX_NUM; i++) begin
                if (h_wr_hit[i])      mbx[i] <= h_wdata;
                else if (c_wr_hit[i]) mbx[i] <= c_wdata;
            end
            // a set in the same cycle as a clear takes priority
            hw_q <= h_wr_hit | (hw_q & ~c_rd_hit);
            cw_q <= c_wr_hit | (cw_q & ~h_rd_hit);
            if (c_we && c_addr == CA_MASK) mask_q <= c_wdata;
            irq_hwr <= |(h_wr_hit & mask_q[MBX_NUM-1:0]);
            irq_hrd <= |(h_rd_hit & mask_q[CW_OFS +: MBX_NUM]);
        end
    end

    assign srst_start = h_we && (h_addr == HA_STAT_HI) && h_wdata[SRST_BIT];
    assign stat_lo    = pack_flags(hw_q, cw_q);
    assign stat_hi    = {{(MBX_DW-1){1'b0}}, ~srst_busy};

    always_comb begin
        h_view = '0;
        if (h_addr == HA_STAT_LO)      h_view = stat_lo;
        else if (h_addr == HA_STAT_HI) h_view = stat_hi;
        else begin
            for (int i = 0; i < MBX_NUM; i++)
                if (h_addr == HADDR_W'(i)) h_view = mbx[i];
        end
    end

    always_comb begin
        c_rdata = '0;
        if (c_addr == CA_STAT_LO)      c_rdata = stat_lo;
        else if (c_addr == CA_STAT_HI) c_rdata = stat_hi;
        else if (c_addr == CA_MASK)    c_rdata = mask_q;
        else begin
            for (int i = 0; i < MBX_NUM; i++)
                if (c_addr == CADDR_W'(i)) c_rdata = mbx[i];
        end
    end
endmodule

// File: rtl/hostmbox_top.sv
module hostmbox_top
    import hostmbox_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SRST_CYCLES = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         host_cs,
    input  logic         host_rd,
    input  logic         host_wr,
    input  logic [2:0]   host_addr,
    input  logic         host_byte_mode,
    input  logic [15:0]  host_wdata,
    output logic [15:0]  host_rdata,
    output logic [1:0]   host_oe,
    output logic         host_ack,
    input  logic [3:0]   core_addr,
    input  logic         core_we,
    input  logic         core_re,
    input  logic [15:0]  core_wdata,
    output logic [15:0]  core_rdata,
    output logic         irq_host_wr,
    output logic         irq_host_rd,
    output logic         sw_rst_pulse
);
    localparam int STB_W = 2;   // bit 1 = write strobe, bit 0 = read strobe

    logic [STB_W-1:0] stb_raw, stb_lvl, stb_rise;
    logic             ack_q, srst_start, rd_live;
    word_t            h_view, h_wd, mask_q;

    assign stb_raw = {host_cs & host_wr, host_cs & host_rd};

    hostmbox_sync #(.STAGES(SYNC_STAGES), .W(STB_W)) u_sync (
        .clk(clk), .rst(rst), .async_in(stb_raw), .level(stb_lvl), .rise(stb_rise)
    );

    always_ff @(posedge clk) begin
        if (rst)              ack_q <= 1'b0;
        else if (|stb_rise)   ack_q <= 1'b1;
        else if (!(|stb_lvl)) ack_q <= 1'b0;
    end

    assign h_wd = fold_width(host_wdata, host_byte_mode);

    hostmbox_regs u_regs (
        .clk(clk), .rst(rst),
        .h_we(stb_rise[1]), .h_re(stb_rise[0]), .h_addr(host_addr), .h_wdata(h_wd),
        .c_we(core_we), .c_re(core_re), .c_addr(core_addr), .c_wdata(core_wdata),
        .srst_busy(sw_rst_pulse), .h_view(h_view), .c_rdata(core_rdata),
        .irq_hwr(irq_host_wr), .irq_hrd(irq_host_rd), .srst_start(srst_start),
        .mask_q(mask_q)
    );

    hostmbox_srst #(.CYCLES(SRST_CYCLES)) u_srst (
        .clk(clk), .rst(rst), .start(srst_start), .busy(sw_rst_pulse)
    );

    assign rd_live    = host_cs & host_rd;
    assign host_oe    = rd_live ? {~host_byte_mode, 1'b1} : 2'b00;
    assign host_rdata = rd_live ? fold_width(h_view, host_byte_mode) : '0;
    assign host_ack   = ack_q;
endmodule

// File: rtl/hostmbox_chk.sv
module hostmbox_chk #(
    parameter int SRST_CYCLES = 5
) (
    input logic        clk,
    input logic        rst,
    input logic        host_cs,
    input logic        host_rd,
    input logic        host_byte_mode,
    input logic [1:0]  host_oe,
    input logic [15:0] host_rdata,
    input logic        irq_host_wr,
    input logic        irq_host_rd,
    input logic        sw_rst_pulse,
    input logic [15:0] mask_q
);
    localparam int RUN_W = $clog2(SRST_CYCLES + 2) + 1;
    logic [RUN_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)               run_len <= '0;
        else if (sw_rst_pulse) run_len <= run_len + 1'b1;
        else                   run_len <= '0;
    end

    AST_SRST_NOT_LONG: assert property (@(posedge clk) disable iff (rst)
        sw_rst_pulse |-> run_len < RUN_W'(SRST_CYCLES)); // R8
    AST_SRST_FULL_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_rst_pulse) |-> run_len == RUN_W'(SRST_CYCLES)); // R8
    AST_BYTE_UPPER_QUIET: assert property (@(posedge clk) disable iff (rst)
        host_byte_mode |-> (!host_oe[1] && host_rdata[15:8] == 8'h00)); // R5
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !(host_cs && host_rd) |-> host_oe == 2'b00); // R9
    AST_HWR_IRQ_ONE: assert property (@(posedge clk) disable iff (rst)
        irq_host_wr |=> !irq_host_wr); // R6
    AST_HRD_IRQ_ONE: assert property (@(posedge clk) disable iff (rst)
        irq_host_rd |=> !irq_host_rd); // R7
    AST_HWR_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_host_wr |-> $past(mask_q[5:0]) != 6'd0); // R6
    AST_HRD_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_host_rd |-> $past(mask_q[13:8]) != 6'd0); // R7
endmodule

bind hostmbox_top hostmbox_chk #(.SRST_CYCLES(SRST_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .host_cs(host_cs), .host_rd(host_rd),
    .host_byte_mode(host_byte_mode), .host_oe(host_oe), .host_rdata(host_rdata),
    .irq_host_wr(irq_host_wr), .irq_host_rd(irq_host_rd),
    .sw_rst_pulse(sw_rst_pulse), .mask_q(mask_q)
);

// File: tb/tb_hostmbox_top.sv
module tb_hostmbox_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_cs = 0, host_rd = 0, host_wr = 0, host_byte_mode = 0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [1:0]  host_oe;
    logic        host_ack;
    logic [3:0]  core_addr = '0;
    logic        core_we = 0, core_re = 0;
    logic [15:0] core_wdata = '0;
    logic [15:0] core_rdata;
    logic        irq_host_wr, irq_host_rd, sw_rst_pulse;

    int checks = 0, errors = 0;
    int n_hwr = 0, n_hrd = 0, n_srst = 0;
    int e_hwr = 0, e_hrd = 0;
    logic [15:0] m_mbx [6];
    logic [5:0]  m_hw = '0, m_cw = '0;
    logic [15:0] m_mask = '0;
    bit          done = 0;

    hostmbox_top dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (irq_host_wr)  n_hwr++;
        if (irq_host_rd)  n_hrd++;
        if (sw_rst_pulse) n_srst++;
    end

    function automatic logic [15:0] fold(logic [15:0] d, logic bm);
        return bm ? {8'h00, d[7:0]} : d;
    endfunction

    function automatic logic [15:0] model_word(int a);
        if (a < 6)  return m_mbx[a];
        if (a == 6) return {2'b00, m_cw, 2'b00, m_hw};
        if (a == 7) return 16'h0001;
        return m_mask;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic core_write(int a, logic [15:0] d);
        @(negedge clk); core_addr = 4'(a); core_wdata = d; core_we = 1;
        @(negedge clk); core_we = 0;
        if (a < 6) begin m_mbx[a] = d; m_cw[a] = 1'b1; end
        if (a == 8) m_mask = d;
    endtask

    task automatic core_read(int a, string tag);
        @(negedge clk); core_addr = 4'(a); core_re = 1; #1;
        check(tag, core_rdata, model_word(a));
        @(negedge clk); core_re = 0;
        if (a < 6) m_hw[a] = 1'b0;
    endtask

    task automatic host_write(int a, logic [15:0] d, logic bm);
        @(negedge clk); host_addr = 3'(a); host_wdata = d; host_byte_mode = bm;
        host_cs = 1; host_wr = 1;
        repeat (4) @(posedge clk); @(negedge clk);
        check("R9 ack taken", host_ack, 1);
        host_wr = 0; host_cs = 0;
        if (a < 6) begin
            m_mbx[a] = fold(d, bm); m_hw[a] = 1'b1;
            if (m_mask[a]) e_hwr++;
        end
        repeat (4) @(posedge clk); @(negedge clk);
        check("R9 ack released", host_ack, 0);
        check("R6 host-write irq count", n_hwr, e_hwr);
    endtask

    task automatic host_read(int a, logic bm);
        @(negedge clk); host_addr = 3'(a); host_byte_mode = bm; host_cs = 1; host_rd = 1;
        repeat (4) @(posedge clk); @(negedge clk);
        check("R4/R5 host rdata", host_rdata, fold(model_word(a), bm));
        check("R5 host oe", host_oe, bm ? 2'b01 : 2'b11);
        host_rd = 0; host_cs = 0;
        if (a < 6) begin
            m_cw[a] = 1'b0;
            if (m_mask[8+a]) e_hrd++;
        end
        repeat (4) @(posedge clk); @(negedge clk);
        check("R9 oe idle", host_oe, 2'b00);
        check("R7 host-read irq count", n_hrd, e_hrd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        for (int i = 0; i < 6; i++) m_mbx[i] = '0;
        repeat (3) @(posedge clk); @(negedge clk); rst = 0;

        // R1 reset state
        check("R1 irq/srst/ack", {irq_host_wr, irq_host_rd, sw_rst_pulse, host_ack}, 0);
        check("R1 oe", host_oe, 2'b00);
        core_read(6, "R1 status6");
        core_read(7, "R1 status7");
        core_read(8, "R1 mask");

        // R2 / R3 full-width write, flag set, core read clears
        host_write(2, 16'hBEEF, 0);
        core_read(6, "R2 host-wrote flag set");
        core_read(2, "R2 data at core");
        core_read(6, "R3 host-wrote flag cleared");

        // R4 core write then host read clears
        core_write(4, 16'h1234);
        core_read(6, "R4 core-wrote flag set");
        host_read(4, 0);
        core_read(6, "R4 core-wrote flag cleared");

        // R5 byte mode
        host_write(0, 16'hABCD, 1);
        core_read(0, "R5 upper byte zeroed");
        core_write(1, 16'h5AA5);
        host_read(1, 1);

        // R6 / R7 mask gating, high edge registers
        core_write(8, 16'h2020);   // write bit 5, read bit 13
        core_read(8, "R6 mask readback");
        host_write(5, 16'h0F0F, 0);   // irq expected
        host_write(3, 16'h0F0F, 0);   // masked off
        host_read(5, 0);              // irq expected
        host_read(3, 0);              // masked off

        // R8 soft reset request
        @(negedge clk); host_addr = 3'd7; host_wdata = 16'h0080; host_byte_mode = 0;
        host_cs = 1; host_wr = 1; core_addr = 4'd7;
        repeat (4) @(posedge clk); @(negedge clk);
        check("R8 pulse active", sw_rst_pulse, 1);
        check("R8 status7 busy", core_rdata, 16'h0000);
        host_wr = 0; host_cs = 0;
        repeat (10) @(posedge clk); @(negedge clk);
        check("R8 pulse length", n_srst, 5);
        core_read(7, "R8 status7 idle");
        host_write(7, 16'h007F, 0);
        check("R8 no pulse without bit 7", n_srst, 5);
        host_write(6, 16'hFFFF, 0);
        core_read(6, "R8 status6 write ignored");

        // R10 host write meets core read of same register
        @(negedge clk); host_addr = 3'd1; host_wdata = 16'hC0DE; host_cs = 1; host_wr = 1;
        @(posedge clk); @(posedge clk); @(negedge clk); core_addr = 4'd1; core_re = 1;
        @(posedge clk); @(negedge clk); core_re = 0; host_wr = 0; host_cs = 0;
        m_mbx[1] = 16'hC0DE; m_hw[1] = 1'b1; if (m_mask[1]) e_hwr++;
        repeat (4) @(posedge clk);
        core_read(6, "R10 host-wrote set wins");
        // R10 core write meets host read of same register
        @(negedge clk); host_addr = 3'd2; host_cs = 1; host_rd = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        core_addr = 4'd2; core_wdata = 16'h7777; core_we = 1;
        @(posedge clk); @(negedge clk); core_we = 0; host_rd = 0; host_cs = 0;
        m_mbx[2] = 16'h7777; m_cw[2] = 1'b1; if (m_mask[10]) e_hrd++;
        repeat (4) @(posedge clk);
        core_read(6, "R10 core-wrote set wins");
        core_read(2, "R10 core data kept");

        // R11 held write strobe acts once
        @(negedge clk); host_addr = 3'd3; host_wdata = 16'h4242; host_cs = 1; host_wr = 1;
        m_mbx[3] = 16'h4242; m_hw[3] = 1'b1; if (m_mask[3]) e_hwr++;
        repeat (4) @(posedge clk);
        core_read(3, "R11 data");
        repeat (6) @(posedge clk);
        core_read(6, "R11 flag stays clear while held");
        @(negedge clk); host_wr = 0; host_cs = 0;
        repeat (4) @(posedge clk);

        // random mix, main function
        core_write(8, 16'($urandom()) & 16'h3F3F);
        for (int k = 0; k < 150; k++) begin
            int op, a;
            op = $urandom_range(0, 3);
            a  = $urandom_range(0, 5);
            case (op)
                0: host_write(a, 16'($urandom()), 1'($urandom_range(0, 1)));
                1: host_read($urandom_range(0, 7), 1'($urandom_range(0, 1)));
                2: core_write(a, 16'($urandom()));
                default: core_read($urandom_range(0, 8), "R2/R3/R4 random core read");
            endcase
        end
        core_read(6, "R2/R4 final flags");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule